// File: doc/BRIEF.md
# Job Ring Occupancy Controller

This block keeps the bookkeeping for a pair of descriptor rings. Software fills the input ring and hardware fills the output ring. The block tracks how many jobs software has posted and how many output slots are occupied. It keeps the input read index and the output write index, each wrapping at its programmed ring size. A job engine pulses `consume` to take one posted job, and pulses `complete` to write one result into the slot given by `cpl_slot`. Software returns a batch of output slots by writing a count.

The block raises an interrupt when jobs complete or when an error occurs. Completion interrupts can be coalesced, either by a completion-count threshold or by a timer. Bookkeeping mistakes by software are reported as coded errors:
- adding more jobs than the ring has room for;
- removing more results than the output ring holds.

A ring reset command waits for in-flight jobs to drain, then clears the ring state. Software sees this progress through a two-bit halt field.

The register port has an 8-word map, listed in R2. Reads are combinational from the current state.

Top module: `ring_occ_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and both `irq` and `fetch_ok` are 0.
- R2: Register addresses are:
  - 0: input size (read/write);
  - 1: jobs-added on write, input room remaining on read;
  - 2: output size (read/write);
  - 3: jobs-removed on write, output slots full on read;
  - 4: configuration;
  - 5: status;
  - 6: command on write, input read index on read;
  - 7: output write index (read).

  Only bits 9:0 of a size write are kept.
- R3: Writing N to address 1 raises the pending job count by N, so room reads size minus pending. An accepted `consume` lowers the pending count by 1 and advances the input read index modulo the input size. `consume` is ignored while nothing is pending.
- R4: An accepted `complete` raises the full count by 1 and advances the output write index modulo the output size. `cpl_slot` always shows that index. Writing N to address 3 lowers the full count by N. `complete` is ignored when no consumed job is outstanding or when the output ring is full.
- R5: A count write and a strobe may fall in the same cycle. Both then apply, acceptance is judged on the values before that cycle, and the count moves by the net amount.
- R6: A jobs-added write larger than the room left is rejected, leaving the count unchanged, and records error type 9. A jobs-removed write larger than the full count is rejected in the same way and records type 8. Either error sets status bit 1, puts the type in bits 11:8, and puts N[13:0] in bits 29:16.
- R7: Status is write-1-to-clear:
  - bit 0 clears the completion flag;
  - bit 1 clears the error flag, type and index;
  - bit 3 returns a completed halt to idle.

  Writing 0 changes nothing.
- R8: Configuration bit 0 masks the interrupt. `irq` equals (status bit 0 or bit 1) and not the mask. With coalescing off (configuration bit 1 = 0), every accepted completion sets status bit 0.
- R9: With coalescing on, status bit 0 sets on the completion that brings the count since the last clear up to configuration bits 15:8.
- R10: With coalescing on, status bit 0 sets at the clock edge that comes T+1 edges after the first uncleared completion, where T is configuration bits 31:16. With nothing pending, it never sets.
- R11: When configuration bit 2 is set and status bit 1 is set, `fetch_ok` is low and `consume` is ignored.
- R12: Writing bit 0 of address 6 sets status bits 3:2 to 1, and `consume` is refused while the halt field is nonzero. Once no consumed job is outstanding, the field becomes 2. At that point the block clears the counts and both indices, sets status bit 1, and records error type 7 with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| consume | input | 1 | Job engine takes one posted job |
| fetch_ok | output | 1 | A `consume` would be accepted now |
| complete | input | 1 | Job engine writes one result entry |
| cpl_slot | output | 10 | Output slot the next result goes to |
| irq | output | 1 | Interrupt request |

## Verification
Software can write a job count in the same cycle that the engine strobes the same ring. Two such pairs are tested:
- a jobs-added write together with a `consume`;
- a jobs-removed write together with a `complete`.

Each pair is driven in a single cycle, and the room, full count and index that follow must show the net change. Acceptance must be judged on the pre-cycle values, so the jobs-removed write is set up to be legal only because an earlier completion made it so. A second coincidence is a halt request arriving with a job still outstanding. That completion must be accepted while the halt field stays at 1, and the clear must happen one edge later.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int unsigned RA_W   = 3;
  localparam int unsigned EIDX_W = 14;

  typedef enum logic [RA_W-1:0] {
    A_IN_SIZE = 3'd0, A_IN_ADD = 3'd1, A_OUT_SIZE = 3'd2, A_OUT_REM = 3'd3,
    A_CFG = 3'd4, A_STAT = 3'd5, A_CMD_RIDX = 3'd6, A_OUT_WIDX = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {H_IDLE = 2'd0, H_BUSY = 2'd1, H_DONE = 2'd2} halt_e;

  localparam logic [3:0] ET_RESET   = 4'd7;
  localparam logic [3:0] ET_REM_OVF = 4'd8;
  localparam logic [3:0] ET_ADD_OVF = 4'd9;

  typedef struct packed {
    logic [15:0] tmr_thr;
    logic [7:0]  cnt_thr;
    logic [4:0]  rsvd;
    logic        halt_on_err;
    logic        coal_en;
    logic        irq_mask;
  } cfg_t;

  localparam logic [31:0] CFG_KEEP = 32'hFFFF_FF07;

  function automatic logic [31:0] pack_status(input logic [EIDX_W-1:0] idx,
      input logic [3:0] etype, input logic [1:0] halt, input logic err,
      input logic done);
    return {2'b00, idx, 4'b0000, etype, 4'b0000, halt, err, done};
  endfunction
endpackage

// File: rtl/ring_track.sv
module ring_track #(
  parameter int unsigned SIZE_W     = 10,
  parameter bit          BULK_FILLS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] size,
  input  logic              step,
  input  logic              bulk_we,
  input  logic [31:0]       bulk_n,
  input  logic              clear,
  output logic [SIZE_W-1:0] count,
  output logic [SIZE_W-1:0] idx,
  output logic              bulk_ovf
);
  function automatic logic [SIZE_W-1:0] wrap_inc(input logic [SIZE_W-1:0] i,
                                                 input logic [SIZE_W-1:0] sz);
    return (sz == '0 || (i + 1'b1) >= sz) ? '0 : i + 1'b1;
  endfunction

  logic [31:0] head_w, cnt_w;

  generate
    if (BULK_FILLS) begin : g_fill
      assign head_w = 32'(size) - 32'(count);
      always_comb begin
        cnt_w = 32'(count);
        if (bulk_we && !bulk_ovf) cnt_w = cnt_w + bulk_n;
        if (step) cnt_w = cnt_w - 32'd1;
      end
    end else begin : g_drain
      assign head_w = 32'(count);
      always_comb begin
        cnt_w = 32'(count);
        if (bulk_we && !bulk_ovf) cnt_w = cnt_w - bulk_n;
        if (step) cnt_w = cnt_w + 32'd1;
      end
    end
  endgenerate

  assign bulk_ovf = bulk_we && (bulk_n > head_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      idx   <= '0;
    end else if (clear) begin
      count <= '0;
      idx   <= '0;
    end else begin
      count <= cnt_w[SIZE_W-1:0];
      if (step) idx <= wrap_inc(idx, size);
    end
  end
endmodule

// File: rtl/irq_coal.sv
module irq_coal #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_thr,
  input  logic [TMR_W-1:0] tmr_thr,
  input  logic             cpl,
  input  logic             clr,
  input  logic             flush,
  output logic             done
);
  logic [CNT_W-1:0] cnt, base, cnt_n;
  logic [TMR_W-1:0] tmr;
  logic fire_cnt, fire_tmr, set;

  assign base     = (clr || flush) ? '0 : cnt;
  assign cnt_n    = (cpl && base != '1) ? base + 1'b1 : base;
  assign fire_cnt = en && cpl && (cnt_n >= cnt_thr);
  assign fire_tmr = en && !clr && !flush && cnt != '0 && !done && (tmr >= tmr_thr);
  assign set      = en ? (fire_cnt || fire_tmr) : cpl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tmr  <= '0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      done <= set || (done && !clr);
      if (clr || flush) tmr <= '0;
      else if (cnt != '0 && !done && tmr != '1) tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/ring_occ_ctrl.sv
module ring_occ_ctrl
  import ring_pkg::*;
#(
  parameter int unsigned SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              consume,
  output logic              fetch_ok,
  input  logic              complete,
  output logic [SIZE_W-1:0] cpl_slot,
  output logic              irq
);
  localparam int unsigned FL_W = SIZE_W + 1;

  cfg_t cfg;
  halt_e halt_st;
  logic [SIZE_W-1:0] in_size, out_size, in_cnt, out_cnt, in_idx, out_idx;
  logic [FL_W-1:0] inflight;
  logic st_done, st_err;
  logic [3:0] st_type;
  logic [EIDX_W-1:0] st_idx;

  // named internal events
  logic we_in_size, we_in_add, we_out_size, we_out_rem, we_cfg, we_stat, we_cmd;
  logic [31:0] w1c;
  logic cons_acc, cpl_acc, in_ovf, out_ovf, halt_fin, rst_req;

  assign we_in_size  = reg_we && reg_addr == A_IN_SIZE;
  assign we_in_add   = reg_we && reg_addr == A_IN_ADD;
  assign we_out_size = reg_we && reg_addr == A_OUT_SIZE;
  assign we_out_rem  = reg_we && reg_addr == A_OUT_REM;
  assign we_cfg      = reg_we && reg_addr == A_CFG;
  assign we_stat     = reg_we && reg_addr == A_STAT;
  assign we_cmd      = reg_we && reg_addr == A_CMD_RIDX;
  assign w1c         = we_stat ? reg_wdata : 32'd0;
  assign rst_req     = we_cmd && reg_wdata[0] && halt_st == H_IDLE;
  assign halt_fin    = halt_st == H_BUSY && inflight == '0;

  assign fetch_ok = in_cnt != '0 && halt_st == H_IDLE && !(st_err && cfg.halt_on_err);
  assign cons_acc = consume && fetch_ok;
  assign cpl_acc  = complete && inflight != '0 && out_cnt < out_size;

  ring_track #(.SIZE_W(SIZE_W), .BULK_FILLS(1'b1)) u_in (
    .clk(clk), .rst_n(rst_n), .size(in_size), .step(cons_acc),
    .bulk_we(we_in_add), .bulk_n(reg_wdata), .clear(halt_fin),
    .count(in_cnt), .idx(in_idx), .bulk_ovf(in_ovf));

  ring_track #(.SIZE_W(SIZE_W), .BULK_FILLS(1'b0)) u_out (
    .clk(clk), .rst_n(rst_n), .size(out_size), .step(cpl_acc),
    .bulk_we(we_out_rem), .bulk_n(reg_wdata), .clear(halt_fin),
    .count(out_cnt), .idx(out_idx), .bulk_ovf(out_ovf));

  irq_coal #(.CNT_W(8), .TMR_W(16)) u_coal (
    .clk(clk), .rst_n(rst_n), .en(cfg.coal_en), .cnt_thr(cfg.cnt_thr),
    .tmr_thr(cfg.tmr_thr), .cpl(cpl_acc), .clr(w1c[0]), .flush(halt_fin),
    .done(st_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_size  <= '0;
      out_size <= '0;
      cfg      <= '0;
      inflight <= '0;
      halt_st  <= H_IDLE;
      st_err   <= 1'b0;
      st_type  <= '0;
      st_idx   <= '0;
    end else begin
      if (we_in_size)  in_size  <= reg_wdata[SIZE_W-1:0];
      if (we_out_size) out_size <= reg_wdata[SIZE_W-1:0];
      if (we_cfg)      cfg      <= cfg_t'(reg_wdata & CFG_KEEP);

      if (halt_fin) inflight <= '0;
      else inflight <= inflight + FL_W'(cons_acc) - FL_W'(cpl_acc);

      unique case (halt_st)
        H_IDLE:  if (rst_req) halt_st <= H_BUSY;
        H_BUSY:  if (halt_fin) halt_st <= H_DONE;
        H_DONE:  if (w1c[3]) halt_st <= H_IDLE;
        default: halt_st <= H_IDLE;
      endcase

      if (halt_fin) begin
        st_err <= 1'b1; st_type <= ET_RESET; st_idx <= '0;
      end else if (in_ovf) begin
        st_err <= 1'b1; st_type <= ET_ADD_OVF; st_idx <= reg_wdata[EIDX_W-1:0];
      end else if (out_ovf) begin
        st_err <= 1'b1; st_type <= ET_REM_OVF; st_idx <= reg_wdata[EIDX_W-1:0];
      end else if (w1c[1]) begin
        st_err <= 1'b0; st_type <= '0; st_idx <= '0;
      end
    end
  end

  assign cpl_slot = out_idx;
  assign irq      = (st_done || st_err) && !cfg.irq_mask;

  always_comb begin
    case (reg_addr)
      A_IN_SIZE:  reg_rdata = 32'(in_size);
      A_IN_ADD:   reg_rdata = 32'(in_size - in_cnt);
      A_OUT_SIZE: reg_rdata = 32'(out_size);
      A_OUT_REM:  reg_rdata = 32'(out_cnt);
      A_CFG:      reg_rdata = 32'(cfg);
      A_STAT:     reg_rdata = pack_status(st_idx, st_type, halt_st, st_err, st_done);
      A_CMD_RIDX: reg_rdata = 32'(in_idx);
      A_OUT_WIDX: reg_rdata = 32'(out_idx);
      default:    reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/ring_occ_chk.sv
module ring_occ_chk #(
  parameter int unsigned SIZE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        halt_st,
  input logic              cons_acc,
  input logic              cpl_acc,
  input logic              in_ovf,
  input logic              we_out_rem,
  input logic [SIZE_W-1:0] in_cnt,
  input logic [SIZE_W-1:0] out_cnt,
  input logic [SIZE_W-1:0] in_idx,
  input logic [SIZE_W-1:0] out_idx,
  input logic              irq_mask,
  input logic              irq
);
  // R12
  halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_st != 2'd3);

  // R12
  halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_st != 2'd0 |-> !cons_acc);

  // R12
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_st == 2'd1 ##1 halt_st == 2'd2 |-> in_cnt == '0 && out_cnt == '0 && in_idx == '0 && out_idx == '0);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  // R6
  add_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ovf && !cons_acc && halt_st != 2'd1 |=> in_cnt == $past(in_cnt));

  // R4
  cpl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_acc && !we_out_rem && halt_st == 2'd0 |=> out_cnt == $past(out_cnt) + 1'b1);
endmodule

bind ring_occ_ctrl ring_occ_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_st(halt_st), .cons_acc(cons_acc),
  .cpl_acc(cpl_acc), .in_ovf(in_ovf), .we_out_rem(we_out_rem),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .in_idx(in_idx), .out_idx(out_idx),
  .irq_mask(cfg.irq_mask), .irq(irq));

// File: tb/tb_ring_occ_ctrl.sv
module tb_ring_occ_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic consume = 1'b0, complete = 1'b0;
  logic fetch_ok, irq;
  logic [9:0] cpl_slot;

  int nchk = 0, nerr = 0;
  int m_in_sz = 0, m_out_sz = 0, m_pend = 0, m_full = 0;
  int m_iidx = 0, m_oidx = 0, m_infl = 0;
  bit m_run = 1'b1;

  ring_occ_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .consume(consume),
    .fetch_ok(fetch_ok), .complete(complete), .cpl_slot(cpl_slot), .irq(irq));

  always #10 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] e);
    reg_addr = a; #1;
    nchk++;
    if (reg_rdata !== e) begin
      nerr++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic e);
    nchk++;
    if (act !== e) begin
      nerr++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  // bench model of acceptance rules (R3, R4)
  task automatic cons();
    consume = 1'b1; tick(); consume = 1'b0;
    if (m_pend > 0 && m_run) begin
      m_pend--; m_iidx = (m_iidx + 1) % m_in_sz; m_infl++;
    end
  endtask

  task automatic cpl();
    complete = 1'b1; tick(); complete = 1'b0;
    if (m_infl > 0 && m_full < m_out_sz) begin
      m_full++; m_oidx = (m_oidx + 1) % m_out_sz; m_infl--;
    end
  endtask

  task automatic add(input int n);
    wr(3'd1, n);
    if (n <= m_in_sz - m_pend) m_pend += n;
  endtask

  task automatic rem(input int n);
    wr(3'd3, n);
    if (n <= m_full) m_full -= n;
  endtask

  task automatic check_model(input string tag);
    expect_reg({tag, " room"}, 3'd1, m_in_sz - m_pend);
    expect_reg({tag, " full"}, 3'd3, m_full);
    expect_reg({tag, " ridx"}, 3'd6, m_iidx);
    expect_reg({tag, " widx"}, 3'd7, m_oidx);
    nchk++;
    if (cpl_slot !== 10'(m_oidx)) begin
      nerr++;
      $display("FAIL %s: cpl_slot actual %0d expected %0d", tag, cpl_slot, m_oidx);
    end
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) expect_reg("R1 reset", 3'(a), 32'd0);
    expect_bit("R1 irq", irq, 1'b0);
    expect_bit("R1 fetch_ok", fetch_ok, 1'b0);
  endtask

  task automatic t_sizes();
    wr(3'd0, 32'hFFFF_F405); expect_reg("R2 in size bits", 3'd0, 32'd5);
    wr(3'd2, 32'h0000_0C08); expect_reg("R2 out size bits", 3'd2, 32'd8);
    wr(3'd0, 32'd4); wr(3'd2, 32'd4);
    m_in_sz = 4; m_out_sz = 4;
  endtask

  task automatic t_input();
    add(3); check_model("R3 add");
    repeat (4) cons();
    check_model("R3 consume empty ignored");
    add(2); repeat (2) cons();
    check_model("R3 read index wrap");
    expect_bit("R3 fetch_ok empty", fetch_ok, 1'b0);
  endtask

  task automatic t_output();
    repeat (5) cpl();
    check_model("R4 fill and full ignored");
    rem(3); cpl(); cpl();
    check_model("R4 remove and no outstanding ignored");
    rem(2);
  endtask

  task automatic t_status();
    expect_reg("R8 done set", 3'd5, 32'd1);
    expect_bit("R8 irq", irq, 1'b1);
    wr(3'd5, 32'd0); expect_reg("R7 write zero", 3'd5, 32'd1);
    wr(3'd5, 32'd1); expect_reg("R7 clear done", 3'd5, 32'd0);
    expect_bit("R7 irq low", irq, 1'b0);
  endtask

  task automatic t_same();
    add(1);
    consume = 1'b1; wr(3'd1, 32'd2); consume = 1'b0;
    m_pend = m_pend + 2 - 1; m_iidx = (m_iidx + 1) % m_in_sz; m_infl++;
    check_model("R5 add with consume");
    cons(); cpl();
    complete = 1'b1; wr(3'd3, 32'd1); complete = 1'b0;
    m_oidx = (m_oidx + 1) % m_out_sz; m_infl--;
    check_model("R5 remove with complete");
    rem(1); wr(3'd5, 32'd1);
  endtask

  task automatic t_ovf();
    add(32'h0001_2345);
    expect_reg("R6 add ovf status", 3'd5, 32'h2345_0902);
    check_model("R6 add ovf count held");
    expect_bit("R6 irq", irq, 1'b1);
    wr(3'd5, 32'd2); expect_reg("R7 clear err", 3'd5, 32'd0);
    rem(2);
    expect_reg("R6 rem ovf status", 3'd5, 32'h0002_0802);
    wr(3'd5, 32'd2);
  endtask

  task automatic t_soe();
    wr(3'd4, 32'd4); add(9);
    expect_bit("R11 fetch_ok low", fetch_ok, 1'b0);
    m_run = 1'b0; cons(); m_run = 1'b1;
    check_model("R11 consume ignored");
    wr(3'd5, 32'd2);
    expect_bit("R11 fetch_ok back", fetch_ok, 1'b1);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_mask();
    wr(3'd4, 32'd1); add(9);
    expect_bit("R8 masked irq", irq, 1'b0);
    expect_reg("R8 masked status", 3'd5, 32'h0009_0902);
    wr(3'd4, 32'd0);
    expect_bit("R8 unmasked irq", irq, 1'b1);
    wr(3'd5, 32'd2);
  endtask

  task automatic t_coal_cnt();
    wr(3'd4, 32'hFFFF_0302);
    add(3); repeat (3) cons();
    cpl(); cpl();
    expect_reg("R9 below threshold", 3'd5, 32'd0);
    cpl();
    expect_reg("R9 threshold reached", 3'd5, 32'd1);
    rem(3); wr(3'd5, 32'd1);
  endtask

  task automatic t_coal_tmr();
    wr(3'd4, 32'h0005_1002);
    cons(); cpl();
    repeat (5) tick();
    expect_reg("R10 timer not yet", 3'd5, 32'd0);
    tick();
    expect_reg("R10 timer fired", 3'd5, 32'd1);
    expect_bit("R10 irq", irq, 1'b1);
    wr(3'd5, 32'd1);
    repeat (10) tick();
    expect_reg("R10 idle no fire", 3'd5, 32'd0);
    rem(1); wr(3'd4, 32'd0);
  endtask

  task automatic t_halt();
    add(1); cons();
    wr(3'd6, 32'd1);
    expect_reg("R12 in progress", 3'd5, 32'h4);
    add(1);
    expect_bit("R12 fetch blocked", fetch_ok, 1'b0);
    m_run = 1'b0; cons(); m_run = 1'b1;
    expect_reg("R12 still draining", 3'd5, 32'h4);
    cpl();
    expect_reg("R12 drain edge", 3'd5, 32'h5);
    tick();
    expect_reg("R12 complete", 3'd5, 32'h0000_070B);
    m_pend = 0; m_full = 0; m_iidx = 0; m_oidx = 0; m_infl = 0;
    check_model("R12 cleared");
    wr(3'd5, 32'h0000_000B);
    expect_reg("R12 halt released", 3'd5, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_sizes();
    t_input();
    t_output();
    t_status();
    t_same();
    t_ovf();
    t_soe();
    t_mask();
    t_coal_cnt();
    t_coal_tmr();
    t_halt();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule